// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns a byte written into its transmit buffer into one asynchronous serial frame on a single output line. A frame opens with a low start bit, carries 7 or 8 data bits least significant bit first, optionally adds a parity bit, and closes with one or two high stop bits. Every bit lasts a fixed number of base-clock ticks; the tick is an enable supplied from outside, so the bit rate is set entirely by the rate of that tick.

The frame shape (parity mode, character length, stop-bit count) is taken from the configuration inputs in the same cycle that the buffer write is accepted and held for the whole frame. The transmitter runs only while both the power input and the transmit-enable input are high, as seen on a base tick. When a base tick finds either one low, the whole transmit circuit is synchronously cleared: any frame in progress is abandoned, the line returns high and no completion pulse is issued. Software is expected to raise power first, then the enable, then write data; to stop, it drops the enable and then power.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0 and `done` is 0; whenever `busy` is 0, `txd` is 1.
- R2: An accepted write makes `txd` send a 0 start bit, then the data bits least significant first, then the stop bits; each bit holds for 16 base ticks, and the start bit appears in the cycle after the write is accepted.
- R3: `len8` = 1 sends `wr_data[7:0]`; `len8` = 0 sends only `wr_data[6:0]` and bit 7 is not transmitted.
- R4: `par_sel` 2'b00 sends no parity bit, 2'b01 sends a parity bit that is always 0, 2'b10 sends odd parity and 2'b11 sends even parity, both computed over the data bits actually sent; the parity bit follows the last data bit.
- R5: `stop2` = 0 sends one stop bit (1); `stop2` = 1 sends two.
- R6: `busy` is 1 from the cycle after an accepted write until the end of the last stop bit; in the cycle `busy` falls, `done` is 1 for exactly one cycle.
- R7: A buffer write while `busy` is 1 is ignored: the frame in progress is unchanged and no second frame follows.
- R8: A buffer write while the transmitter is not enabled (either `tx_en` or `pwr_on` low) is ignored and `txd` stays 1.
- R9: On a base tick where `pwr_on & tx_en` is 0 the transmit circuit clears at that clock edge: `busy` 0, `txd` 1, `done` 0, even if that edge would have ended the last stop bit. A low level on `tx_en` that no base tick samples has no effect.
- R10: After being disabled, the transmitter becomes enabled at the first base tick that samples `pwr_on & tx_en` high, and a write in any later cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on | input | 1 | Power/operation enable for the transmitter |
| tx_en | input | 1 | Transmit enable, sampled on base ticks |
| par_sel | input | 2 | Parity mode: 00 none, 01 zero, 10 odd, 11 even |
| len8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| stop2 | input | 1 | 1 = two stop bits, 0 = one |
| base_tick | input | 1 | Base-clock enable, one cycle wide |
| wr_stb | input | 1 | Transmit buffer write strobe |
| wr_data | input | 8 | Transmit buffer write data |
| txd | output | 1 | Serial output line, idle high |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at end of the last stop bit |

## Verification
The sharpest collision is a disable landing on the very base tick that ends the last stop bit: completion and circuit clear meet in one edge, and the clear must win with no `done` pulse. The bench provokes it by dropping `tx_en` in the cycle just before the final bit edge and judges `done`, `busy` and `txd` right after that edge. A second collision, a buffer write arriving mid-frame, is injected into a running frame and judged by the unchanged bit pattern and the absence of any follow-on frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_e;

  // Parity bit value given the mode and whether the sent data has an odd count of ones.
  function automatic logic par_value(par_mode_e mode, logic ones_odd);
    case (mode)
      PAR_ODD:  return ~ones_odd;
      PAR_EVEN: return ones_odd;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tx_enable_gate.sv
module tx_enable_gate (
  input  logic clk,
  input  logic rst,
  input  logic base_tick,
  input  logic pwr_on,
  input  logic tx_en,
  output logic live
);
  logic en_q;
  logic kill;

  assign kill = base_tick & ~(pwr_on & tx_en);
  assign live = en_q & ~kill;

  always_ff @(posedge clk) begin
    if (rst)            en_q <= 1'b0;
    else if (base_tick) en_q <= pwr_on & tx_en;
  end

  assert_reenable_R10: assert property (@(posedge clk) disable iff (rst)
    (!en_q && base_tick && pwr_on && tx_en) |=> en_q);

  assert_tick_low_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (base_tick && !(pwr_on && tx_en)) |=> !en_q);

endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic bit_end
);
  localparam int TW = $clog2(TICKS_PER_BIT + 1);
  localparam logic [TW-1:0] LAST = TW'(TICKS_PER_BIT - 1);

  logic [TW-1:0] cnt_q;

  assign bit_end = run & tick & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) cnt_q <= '0;
    else if (tick) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_count_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

endmodule

// File: rtl/tx_frame_former.sv
module tx_frame_former
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  par_mode_e          mode,
  input  logic               len_full,
  input  logic               stop_two,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);
  logic [DATA_W-1:0] sent;
  int unsigned       pos;

  always_comb begin
    sent = data;
    if (!len_full) sent[DATA_W-1] = 1'b0;
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (len_full || i < DATA_W - 1) frame[i+1] = data[i];
    end
    pos = len_full ? DATA_W + 1 : DATA_W;
    if (mode != PAR_NONE) begin
      frame[pos] = par_value(mode, ^sent);
      pos = pos + 1;
    end
    nbits = CNT_W'(pos + (stop_two ? 2 : 1));
  end

  assert_len_bounds_R5: assert final (nbits >= CNT_W'(DATA_W + 1) && nbits <= CNT_W'(FRAME_W));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_on,
  input  logic              tx_en,
  input  logic [1:0]        par_sel,
  input  logic              len8,
  input  logic              stop2,
  input  logic              base_tick,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic               live;
  logic               bit_end;
  logic               accept;
  logic [FRAME_W-1:0] frame_w;
  logic [CNT_W-1:0]   nbits_w;

  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   left_q;
  logic               busy_q;
  logic               done_q;
  logic               txd_q;

  tx_enable_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .base_tick (base_tick),
    .pwr_on    (pwr_on),
    .tx_en     (tx_en),
    .live      (live)
  );

  tx_frame_former #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_form (
    .data     (wr_data),
    .mode     (par_mode_e'(par_sel)),
    .len_full (len8),
    .stop_two (stop2),
    .frame    (frame_w),
    .nbits    (nbits_w)
  );

  tx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (~live | accept),
    .run     (busy_q),
    .tick    (base_tick),
    .bit_end (bit_end)
  );

  assign accept = live & wr_stb & ~busy_q;

  always_ff @(posedge clk) begin
    if (rst || !live) begin
      frame_q <= '1;
      left_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      txd_q   <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        frame_q <= frame_w;
        left_q  <= nbits_w - 1'b1;
        busy_q  <= 1'b1;
        txd_q   <= frame_w[0];
      end else if (busy_q && bit_end) begin
        if (left_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          txd_q  <= 1'b1;
        end else begin
          frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
          txd_q   <= frame_q[1];
          left_q  <= left_q - 1'b1;
        end
      end
    end
  end

  assign txd  = txd_q;
  assign busy = busy_q;
  assign done = done_q;

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> txd_q);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> !txd_q);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  assert_done_closes_busy_R6: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && $past(busy_q)));

  assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && wr_stb && !bit_end) |=> ($stable(left_q) || !busy_q));

  assert_clear_on_disable_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!live) |-> (!busy_q && txd_q && !done_q));

endmodule

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;
  localparam int CLK_P = 10;
  localparam int NV = 8;
  // {par_sel[1:0], len8, stop2, data[7:0]}
  localparam logic [11:0] VEC [NV] = '{
    {2'b00, 1'b1, 1'b0, 8'hA5},
    {2'b01, 1'b1, 1'b0, 8'hFF},
    {2'b10, 1'b1, 1'b0, 8'h03},
    {2'b11, 1'b1, 1'b1, 8'h07},
    {2'b10, 1'b0, 1'b0, 8'h80},
    {2'b11, 1'b0, 1'b1, 8'hFE},
    {2'b00, 1'b0, 1'b1, 8'h55},
    {2'b01, 1'b0, 1'b0, 8'h00}
  };
  localparam int EXP_N [NV] = '{10, 11, 11, 12, 10, 11, 10, 10};

  logic clk = 0, rst = 1, pwr_on = 0, tx_en = 0, len8 = 1, stop2 = 0;
  logic base_tick = 1, wr_stb = 0;
  logic [1:0] par_sel = 2'b00;
  logic [7:0] wr_data = 8'h00;
  logic txd, busy, done;
  int n_cmp = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_frame_tx uut (
    .clk(clk), .rst(rst), .pwr_on(pwr_on), .tx_en(tx_en), .par_sel(par_sel),
    .len8(len8), .stop2(stop2), .base_tick(base_tick), .wr_stb(wr_stb),
    .wr_data(wr_data), .txd(txd), .busy(busy), .done(done)
  );

  task automatic check(input logic ok, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic bench_frame(input logic [11:0] s, output logic [11:0] b, output int n);
    int dl, ones, k;
    dl = s[9] ? 8 : 7;
    ones = 0;
    b = '1;
    b[0] = 1'b0;
    for (int i = 0; i < dl; i++) begin
      b[1+i] = s[i];
      ones += int'(s[i]);
    end
    k = 1 + dl;
    case (s[11:10])
      2'b01: begin b[k] = 1'b0; k++; end
      2'b10: begin b[k] = ~ones[0]; k++; end
      2'b11: begin b[k] = ones[0]; k++; end
      default: ;
    endcase
    n = k + (s[8] ? 2 : 1);
  endtask

  task automatic start_write(input logic [11:0] s);
    @(negedge clk);
    par_sel = s[11:10]; len8 = s[9]; stop2 = s[8]; wr_data = s[7:0]; wr_stb = 1;
    @(negedge clk);
    wr_stb = 0;
  endtask

  task automatic send_frame(input logic [11:0] s, input int exp_n, input int inj);
    logic [11:0] eb, gb;
    int n;
    bench_frame(s, eb, n);
    check(n == exp_n, "R3/R4/R5 frame length", n, exp_n);
    start_write(s);
    check(busy && !txd, "R6/R2 busy and start bit after write", {busy, txd}, 2'b10);
    gb = '1;
    for (int c = 1; c <= 16*n; c++) begin
      if (c == inj) begin wr_stb = 1; wr_data = ~s[7:0]; end
      else if (c == inj + 1) wr_stb = 0;
      @(negedge clk);
      if (c % 16 == 8) gb[c/16] = txd;
      if (c == 16*n - 1) check(busy && !done, "R6 busy through last stop bit", {busy, done}, 2'b10);
    end
    check(done && !busy && txd, "R6 done at end of frame", {done, busy, txd}, 3'b101);
    check(gb == eb, "R2/R3/R4/R5 frame bits", gb, eb);
    @(negedge clk);
    check(!done, "R6 done is one cycle", done, 0);
    if (inj > 0) begin
      int extra = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (busy || !txd) extra++;
      end
      check(extra == 0, "R7 write while busy ignored", extra, 0);
    end
  endtask

  task automatic expect_idle(input string what);
    int bad = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (busy || !txd || done) bad++;
    end
    check(bad == 0, what, bad, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(txd && !busy && !done, "R1 reset state", {txd, busy, done}, 3'b100);

    // startup order: power, then enable, then data
    pwr_on = 1;
    @(negedge clk);
    tx_en = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) send_frame(VEC[v], EXP_N[v], 0);

    // R7: write injected mid-frame
    send_frame(VEC[3], EXP_N[3], 70);

    // R9: disable mid-frame
    start_write(VEC[0]);
    repeat (50) @(negedge clk);
    tx_en = 0;
    @(negedge clk);
    check(!busy && txd && !done, "R9 disable abandons frame", {busy, txd, done}, 3'b010);

    // R8: write while enable low
    start_write(VEC[1]);
    expect_idle("R8 write with tx_en low ignored");

    // R10: re-enable then send
    tx_en = 1;
    @(negedge clk);
    send_frame(VEC[2], EXP_N[2], 0);

    // R8: power low with enable high
    pwr_on = 0;
    @(negedge clk);
    start_write(VEC[1]);
    expect_idle("R8 write with power low ignored");
    pwr_on = 1;
    @(negedge clk);

    // R9: disable on the edge that ends the last stop bit (frame of 10 bits)
    start_write(VEC[0]);
    for (int c = 1; c < 160; c++) @(negedge clk);
    check(busy && !done, "R9 still busy before final edge", {busy, done}, 2'b10);
    tx_en = 0;
    @(negedge clk);
    check(!done && !busy && txd, "R9 disable beats done", {done, busy, txd}, 3'b001);
    tx_en = 1;
    @(negedge clk);

    // R9: enable low pulse not seen by any base tick has no effect
    begin
      int seen = 0;
      logic [11:0] eb;
      int n;
      bench_frame(VEC[1], eb, n);
      start_write(VEC[1]);
      repeat (4) @(negedge clk);
      base_tick = 0;
      tx_en = 0;
      repeat (2) @(negedge clk);
      tx_en = 1;
      @(negedge clk);
      base_tick = 1;
      check(busy, "R9 unsampled low pulse keeps frame", busy, 1);
      for (int c = 0; c < 16*n + 10; c++) begin
        @(negedge clk);
        if (done) seen++;
      end
      check(seen == 1, "R9 frame completes after unsampled pulse", seen, 1);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule